// File: doc/BRIEF.md
# Banked Nibble-Register BCD Calendar Clock

This block is a real-time clock core that keeps seconds, minutes, hours (24-hour), day of week, day of month, month and a four-digit year. Every field is stored as its own 4-bit BCD digit register. A one-second tick input advances the time, and a carry passes from each field to the next, with month lengths and leap years taken into account.

Software reaches the clock through a 4-bit parallel register port: a 4-bit address, 4-bit write and read data, a write strobe and a read strobe. The digit registers sit behind a bank-switched window. The control nibble at the top address can be seen in every bank. It carries a read-only busy flag, a stop bit and a two-bit bank select.

To set the time, software sets stop, writes the digits, then clears stop. To read the time, it waits until busy reads 0 and then reads the digits.

Top module: `nibble_rtc`

## Requirements
- R1: After reset the clock reads 00:00:00, day of week 0, day 01, month 01, year 2000, and the control nibble reads 0.
- R2: Bank 0 digit addresses are: 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 day of week, 7 day units, 8 day tens, 9 month units, 10 month tens, 11 year units, 12 year tens, 13 year hundreds, 14 year thousands. A write lands on the clock edge where the write strobe is sampled. Reads are combinational while the read strobe is high, and rdData is 0 while the read strobe is low.
- R3: Seconds and minutes count 00..59 and then wrap to 00 with a carry. Hours count 00..23 and then wrap to 00 with a carry into the day.
- R4: Day of week steps 0..6 on each day carry and wraps from 6 to 0.
- R5: Day of month wraps to 01 after the last day of the month (30 for months 4, 6, 9 and 11, 31 for the other months except February). Month wraps from 12 to 01 and increments the year.
- R6: February has 29 days in a leap year, otherwise 28. A year is leap if it is divisible by 4 and not by 100, or if it is divisible by 400.
- R7: The year is a four-digit BCD counter that wraps from 9999 to 0000.
- R8: Address 15 is the control nibble in every bank. Bit 0 is busy and ignores writes. Bit 1 is stop. Bits 3:2 are the bank select.
- R9: In banks 1 to 3, addresses 0 to 14 read 0, and writes to them change nothing.
- R10: A tick that arrives while stop is set is discarded: busy does not rise and no digit changes. After stop is cleared, ticks advance the clock again.
- R11: A tick accepted at edge N makes busy read 1 after edges N and N+1 and 0 after edge N+2. The digits change at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse once per second |
| addr | input | 4 | Register address |
| wrData | input | 4 | Write data nibble |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 4 | Read data nibble |

## Verification
The bench sweeps 3700 consecutive seconds across a year boundary. It also sweeps every valid day from the 28th to the end of the month, for all twelve months, in a common year, a leap year, a century year that is not leap (1900) and a 400-year leap year (2000).

A design with the wrong month-length table or the wrong century rule would roll February or a 30-day month over to the 1st on the wrong day. A design that gets the year carry wrong would fail at 9999 or at 1999→2000.

The bench checks the busy window edge by edge after every tick. A short busy window would let software read digits while they are still changing. The bench also confirms that busy ignores writes, that a stopped clock drops ticks without raising busy, and that a write in banks 1 to 3 does not change any bank 0 digit.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NIB_W      = 4;
  localparam int NUM_DIGITS = 15;
  localparam logic [3:0] CTRL_ADDR = 4'hF;

  // bank 0 digit slots (decoded by software, so positions are fixed)
  localparam int SEC_U = 0;
  localparam int SEC_T = 1;
  localparam int MIN_U = 2;
  localparam int MIN_T = 3;
  localparam int HR_U  = 4;
  localparam int HR_T  = 5;
  localparam int DOW   = 6;
  localparam int DAY_U = 7;
  localparam int DAY_T = 8;
  localparam int MON_U = 9;
  localparam int MON_T = 10;
  localparam int YR_U  = 11;
  localparam int YR_T  = 12;
  localparam int YR_H  = 13;
  localparam int YR_K  = 14;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic digitWr;
  } dpStrobe_t;

  // returns {carry, next digit}; wraps to 0 once the digit reaches lim
  function automatic logic [4:0] bcdInc(input logic [3:0] val, input logic [3:0] lim);
    if (val >= lim) return {1'b1, 4'd0};
    return {1'b0, val + 4'd1};
  endfunction

  function automatic logic [3:0] rstValue(input int idx);
    if (idx == DAY_U || idx == MON_U) return 4'd1;
    if (idx == YR_K) return 4'd2;
    return 4'd0;
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int BUSY_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic [3:0] addr,
  input  logic [2:0] ctrlWrBits,
  input  logic       wrEn,
  output logic       stopBit,
  output logic [1:0] bankSel,
  output logic       busyFlag,
  output dpStrobe_t  strobe
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic             advPend;
  logic             tickTaken;

  assign tickTaken = secTick && !stopBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopBit <= 1'b0;
      bankSel <= 2'd0;
      busyCnt <= '0;
      advPend <= 1'b0;
    end else begin
      if (wrEn && addr == CTRL_ADDR) begin
        bankSel <= ctrlWrBits[2:1];
        stopBit <= ctrlWrBits[0];
      end
      advPend <= tickTaken;
      if (tickTaken) busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busyFlag       = busyCnt != '0;
  assign strobe.advance = advPend;
  assign strobe.digitWr = wrEn && addr != CTRL_ADDR && bankSel == 2'd0;
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic [3:0] addr,
  input  logic [3:0] wrData,
  output logic [3:0] rdDigit,
  output logic [3:0] secUnits,
  output logic [3:0] dowDigit
);
  logic [3:0] dig [NUM_DIGITS];
  logic [3:0] nxt [NUM_DIGITS];

  logic [4:0] s0, s1, m0, m1, h0, d0, y0, y1, y2, y3;
  logic       minCarry, hrCarry, hourWrap, dayCarry, monCarry, yrCarry, leap;
  logic [6:0] monBin, dayBin, lastDay, yy, cc;

  always_comb begin
    for (int i = 0; i < NUM_DIGITS; i++) nxt[i] = dig[i];

    // seconds and minutes
    s0 = bcdInc(dig[SEC_U], 4'd9);
    s1 = bcdInc(dig[SEC_T], 4'd5);
    m0 = bcdInc(dig[MIN_U], 4'd9);
    m1 = bcdInc(dig[MIN_T], 4'd5);
    nxt[SEC_U] = s0[3:0];
    if (s0[4]) nxt[SEC_T] = s1[3:0];
    minCarry = s0[4] && s1[4];
    if (minCarry) nxt[MIN_U] = m0[3:0];
    if (minCarry && m0[4]) nxt[MIN_T] = m1[3:0];
    hrCarry = minCarry && m0[4] && m1[4];

    // hours 00..23
    hourWrap = dig[HR_T] >= 4'd2 && dig[HR_U] >= 4'd3;
    h0 = bcdInc(dig[HR_U], 4'd9);
    if (hrCarry) begin
      if (hourWrap) begin
        nxt[HR_U] = 4'd0;
        nxt[HR_T] = 4'd0;
      end else begin
        nxt[HR_U] = h0[3:0];
        if (h0[4]) nxt[HR_T] = dig[HR_T] + 4'd1;
      end
    end
    dayCarry = hrCarry && hourWrap;

    // day of week
    if (dayCarry) nxt[DOW] = (dig[DOW] >= 4'd6) ? 4'd0 : dig[DOW] + 4'd1;

    // leap year from BCD digits
    yy   = 7'(dig[YR_T]) * 7'd10 + 7'(dig[YR_U]);
    cc   = 7'(dig[YR_K]) * 7'd10 + 7'(dig[YR_H]);
    leap = (yy != 7'd0) ? (yy[1:0] == 2'd0) : (cc[1:0] == 2'd0);

    // month length
    monBin = 7'(dig[MON_T]) * 7'd10 + 7'(dig[MON_U]);
    dayBin = 7'(dig[DAY_T]) * 7'd10 + 7'(dig[DAY_U]);
    case (monBin)
      7'd2:                     lastDay = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  lastDay = 7'd30;
      default:                  lastDay = 7'd31;
    endcase
    monCarry = dayCarry && dayBin >= lastDay;

    d0 = bcdInc(dig[DAY_U], 4'd9);
    if (dayCarry) begin
      if (monCarry) begin
        nxt[DAY_U] = 4'd1;
        nxt[DAY_T] = 4'd0;
      end else begin
        nxt[DAY_U] = d0[3:0];
        if (d0[4]) nxt[DAY_T] = dig[DAY_T] + 4'd1;
      end
    end

    // month 01..12
    yrCarry = monCarry && monBin >= 7'd12;
    if (monCarry) begin
      if (yrCarry) begin
        nxt[MON_U] = 4'd1;
        nxt[MON_T] = 4'd0;
      end else if (dig[MON_U] >= 4'd9) begin
        nxt[MON_U] = 4'd0;
        nxt[MON_T] = dig[MON_T] + 4'd1;
      end else begin
        nxt[MON_U] = dig[MON_U] + 4'd1;
      end
    end

    // four-digit year chain
    y0 = bcdInc(dig[YR_U], 4'd9);
    y1 = bcdInc(dig[YR_T], 4'd9);
    y2 = bcdInc(dig[YR_H], 4'd9);
    y3 = bcdInc(dig[YR_K], 4'd9);
    if (yrCarry) nxt[YR_U] = y0[3:0];
    if (yrCarry && y0[4]) nxt[YR_T] = y1[3:0];
    if (yrCarry && y0[4] && y1[4]) nxt[YR_H] = y2[3:0];
    if (yrCarry && y0[4] && y1[4] && y2[4]) nxt[YR_K] = y3[3:0];
  end

  for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
    logic [3:0] q;
    logic       wrHit;
    assign wrHit = strobe.digitWr && addr == 4'(gi);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                q <= rstValue(gi);
      else if (wrHit)           q <= wrData;
      else if (strobe.advance)  q <= nxt[gi];
    end
    assign dig[gi] = q;
  end

  always_comb begin
    rdDigit = '0;
    for (int i = 0; i < NUM_DIGITS; i++)
      if (addr == 4'(i)) rdDigit = dig[i];
  end

  assign secUnits = dig[SEC_U];
  assign dowDigit = dig[DOW];
endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
  import rtc_pkg::*;
#(
  parameter int BUSY_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic [3:0] addr,
  input  logic [3:0] wrData,
  input  logic       wrEn,
  input  logic       rdEn,
  output logic [3:0] rdData
);
  dpStrobe_t  strobe;
  logic       stopBit;
  logic [1:0] bankSel;
  logic       busyFlag;
  logic [3:0] rdDigit;
  logic [3:0] secUnits;
  logic [3:0] dowDigit;

  rtc_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .secTick    (secTick),
    .addr       (addr),
    .ctrlWrBits (wrData[3:1]),
    .wrEn       (wrEn),
    .stopBit    (stopBit),
    .bankSel    (bankSel),
    .busyFlag   (busyFlag),
    .strobe     (strobe)
  );

  rtc_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addr     (addr),
    .wrData   (wrData),
    .rdDigit  (rdDigit),
    .secUnits (secUnits),
    .dowDigit (dowDigit)
  );

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == CTRL_ADDR)    rdData = {bankSel, stopBit, busyFlag};
      else if (bankSel == 2'd0) rdData = rdDigit;
    end
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       secTick,
  input logic [3:0] addr,
  input logic       wrEn,
  input logic       rdEn,
  input logic [3:0] rdData,
  input logic       busy,
  input logic       stop,
  input logic [1:0] bank,
  input logic [3:0] secU,
  input logic [3:0] dow
);
  // R2: idle read port drives zero
  p_idle_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == 4'd0);

  // R4: day of week only steps by one or wraps 6 -> 0 when not written
  p_dow_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(dow) && !$past(wrEn)) |->
      (dow == $past(dow) + 4'd1) || ($past(dow) == 4'd6 && dow == 4'd0));

  // R8: control nibble reflects the control state in any bank
  p_ctrl_view_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 4'hF) |-> (rdData[3:2] == bank && rdData[1] == stop));

  // R9: other banks hide the digits
  p_bank_hidden_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && bank != 2'd0 && addr != 4'hF) |-> rdData == 4'd0);

  // R10: a tick while stopped does not raise busy
  p_stop_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && stop && !busy) |=> !busy);

  // R11: an accepted tick raises busy
  p_tick_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !stop) |=> busy);

  // R11: a digit change not caused by a write happens under busy
  p_busy_covers_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(secU) && !$past(wrEn)) |-> busy);
endmodule

bind nibble_rtc rtc_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .secTick (secTick),
  .addr    (addr),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .rdData  (rdData),
  .busy    (busyFlag),
  .stop    (stopBit),
  .bank    (bankSel),
  .secU    (secUnits),
  .dow     (dowDigit)
);

// File: tb/nibble_rtc_bench.sv
`timescale 1ns/1ps
module nibble_rtc_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [3:0] addr = '0;
  logic [3:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [3:0] rdData;

  int nChecks = 0;
  int nFails  = 0;

  int mSec, mMin, mHr, mDow, mDay, mMon, mYr;

  nibble_rtc u_nibble_rtc (
    .clk(clk), .rstN(rstN), .secTick(secTick), .addr(addr),
    .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int monthLen(input int m, input int y);
    bit lp;
    lp = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic modelTick();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHr++;
        if (mHr == 24) begin
          mHr = 0; mDow = (mDow + 1) % 7; mDay++;
          if (mDay > monthLen(mMon, mYr)) begin
            mDay = 1; mMon++;
            if (mMon == 13) begin
              mMon = 1; mYr = (mYr + 1) % 10000;
            end
          end
        end
      end
    end
  endtask

  function automatic logic [59:0] expVec();
    logic [59:0] v;
    v[3:0]   = 4'(mSec % 10);  v[7:4]   = 4'(mSec / 10);
    v[11:8]  = 4'(mMin % 10);  v[15:12] = 4'(mMin / 10);
    v[19:16] = 4'(mHr % 10);   v[23:20] = 4'(mHr / 10);
    v[27:24] = 4'(mDow);
    v[31:28] = 4'(mDay % 10);  v[35:32] = 4'(mDay / 10);
    v[39:36] = 4'(mMon % 10);  v[43:40] = 4'(mMon / 10);
    v[47:44] = 4'(mYr % 10);   v[51:48] = 4'((mYr / 10) % 10);
    v[55:52] = 4'((mYr / 100) % 10); v[59:56] = 4'(mYr / 1000);
    return v;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] v);
    addr = a; rdEn = 1'b1;
    #0.2;
    v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic readDigits(output logic [59:0] v);
    logic [3:0] n;
    for (int i = 0; i < 15; i++) begin
      rd(4'(i), n);
      v[i*4 +: 4] = n;
    end
  endtask

  task automatic compareAll(input string req);
    logic [59:0] got;
    readDigits(got);
    check(got == expVec(), req, 64'(got), 64'(expVec()));
  endtask

  task automatic setAll(input int s, input int mi, input int h, input int dw,
                        input int d, input int mo, input int y);
    logic [59:0] v;
    mSec = s; mMin = mi; mHr = h; mDow = dw; mDay = d; mMon = mo; mYr = y;
    v = expVec();
    for (int i = 0; i < 15; i++) wr(4'(i), v[i*4 +: 4]);
  endtask

  // R11 busy window; R10 when the tick is dropped
  task automatic doTick(input bit accepted);
    logic [3:0] c;
    logic [2:0] seen;
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    rd(4'hF, c); seen[2] = c[0];
    @(negedge clk);
    rd(4'hF, c); seen[1] = c[0];
    @(negedge clk);
    rd(4'hF, c); seen[0] = c[0];
    if (accepted) begin
      modelTick();
      check(seen == 3'b110, "R11", 64'(seen), 64'(3'b110));
    end else begin
      check(seen == 3'b000, "R10", 64'(seen), 64'(3'b000));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [3:0] c;
    int years [4];
    years[0] = 2023; years[1] = 2024; years[2] = 1900; years[3] = 2000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    mSec = 0; mMin = 0; mHr = 0; mDow = 0; mDay = 1; mMon = 1; mYr = 2000;
    compareAll("R1");
    rd(4'hF, c);
    check(c == 4'd0, "R1", 64'(c), 64'd0);

    // R2 map and single-digit write
    setAll(7, 3, 12, 2, 15, 8, 2031);
    compareAll("R2");
    wr(4'd11, 4'd5); mYr = 2035;
    compareAll("R2");
    addr = 4'd0; rdEn = 1'b0; #0.2;
    check(rdData == 4'd0, "R2", 64'(rdData), 64'd0);

    // R3 long sweep across hour, day, month and year carries
    setAll(0, 59, 22, 6, 31, 12, 1999);
    for (int k = 0; k < 3700; k++) begin
      doTick(1'b1);
      compareAll("R3");
    end

    // R5 and R6 month-end sweep
    for (int yi = 0; yi < 4; yi++)
      for (int m = 1; m <= 12; m++)
        for (int d = 28; d <= monthLen(m, years[yi]); d++) begin
          setAll(59, 59, 23, 3, d, m, years[yi]);
          doTick(1'b1);
          compareAll((m == 2) ? "R6" : "R5");
        end

    // R7 year wrap and R4 day-of-week wrap
    setAll(59, 59, 23, 6, 31, 12, 9999);
    doTick(1'b1);
    compareAll("R7");
    rd(4'd6, c);
    check(c == 4'd0, "R4", 64'(c), 64'd0);

    // R8 busy ignores writes
    wr(4'hF, 4'b0001);
    rd(4'hF, c);
    check(c == 4'd0, "R8", 64'(c), 64'd0);

    // R10 stop drops ticks, clearing stop resumes
    setAll(30, 10, 5, 1, 9, 3, 2022);
    wr(4'hF, 4'b0010);
    rd(4'hF, c);
    check(c == 4'b0010, "R8", 64'(c), 64'(4'b0010));
    doTick(1'b0);
    compareAll("R10");
    wr(4'hF, 4'b0000);
    doTick(1'b1);
    compareAll("R10");

    // R9 banks 1..3 hide digits and ignore writes
    for (int b = 1; b < 4; b++) begin
      wr(4'hF, 4'(b << 2));
      rd(4'hF, c);
      check(c == 4'(b << 2), "R8", 64'(c), 64'(b << 2));
      for (int a = 0; a < 15; a++) begin
        rd(4'(a), c);
        check(c == 4'd0, "R9", 64'(c), 64'd0);
      end
      wr(4'd0, 4'd7);
      wr(4'd9, 4'd4);
    end
    wr(4'hF, 4'b0000);
    compareAll("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule